// File: doc/BRIEF.md
# Address Translation Buffer with Access Check

This block is the translation cache in front of one memory access stream. It turns a virtual address into a physical address by looking up a small fully associative set of recently used page mappings. In the same lookup it checks the request against the rights stored with the mapping. A request that hits and is allowed returns the physical address and a two-bit cache-mode code one cycle after it is accepted. A request that breaks the stored rights returns an access fault instead of a translation.

When no entry matches, the block raises a walk request toward an external table walker and holds the stalled request. The walker answers through a fill port with a descriptor. A valid descriptor is installed over the entry chosen by a round-robin pointer, and the held request is then looked up again. A descriptor marked invalid is not installed; the request ends in an access fault.

Software-visible controls are reduced to three inputs: a translation enable, a page-size select and a flush-all pulse. The flush-all pulse must be used whenever the page size or the tables change.

Top module: `mmu_xlate_cache`

## Requirements
- R1: A request accepted while `req_ready` is high that hits a valid entry with its rights met produces `rsp_valid` one cycle later, with `rsp_fault` low, `rsp_pa` made of the stored frame and the page offset of the request, and no walk request.
- R2: A write (`req_write`=1) that hits an entry whose write-protect flag is 1 responds with `rsp_fault`=1; a read of the same page translates normally.
- R3: A user access (`req_super`=0) that hits an entry whose supervisor-only flag is 1 responds with `rsp_fault`=1; a supervisor access to the same page translates normally.
- R4: A fill whose two-bit valid-type field is 00 answers the held request with `rsp_fault`=1 in the cycle after the fill and installs nothing, so the next access to that page raises a new walk request. Any non-zero valid type is a usable descriptor.
- R5: With `page_8k`=0 the page is 4 KB: tag is address bits 31..12 and offset bits 11..0. With `page_8k`=1 the page is 8 KB: tag bit 0 (address bit 12) is ignored in the match and bit 0 of the stored frame is replaced by address bit 12.
- R6: A one-cycle `flush_all` pulse invalidates every entry, so the next access to any page raises a walk request.
- R7: `rsp_cmode` on a translated response carries the cache-mode code of the descriptor unchanged: 00 write-through cacheable, 01 copy-back cacheable, 10 non-cacheable serialized, 11 non-cacheable.
- R8: With `xlate_en`=0 every request responds one cycle after acceptance with `rsp_pa` equal to `req_va`, `rsp_cmode`=00 and `rsp_fault`=0, whatever the stored rights, and no walk request.
- R9: On a miss, `walk_req` rises one cycle after acceptance with `walk_va` equal to the request address and holds, together with `req_ready` low, until a fill is given; a valid fill produces the response two cycles after the fill is sampled.
- R10: The buffer has 64 entries replaced in round-robin order: after a flush, 65 fills of distinct pages evict only the first page filled.
- R11: Every fault response has `rsp_pa`=0 and `rsp_cmode`=00.
- R12: After reset `req_ready`=1, `rsp_valid`=0, `walk_req`=0 and no entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlate_en | input | 1 | Translation enable; 0 passes addresses through |
| page_8k | input | 1 | Page size select: 0 = 4 KB, 1 = 8 KB |
| flush_all | input | 1 | Invalidate every entry |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Block can take a request this cycle |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_super | input | 1 | 1 = supervisor access, 0 = user access |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_pa | output | 32 | Physical address (0 on a fault) |
| rsp_cmode | output | 2 | Cache-mode code of the page |
| rsp_fault | output | 1 | Access fault instead of a translation |
| walk_req | output | 1 | Miss: asks the walker for a descriptor |
| walk_va | output | 32 | Address the walker must resolve |
| fill_valid | input | 1 | Walker answer strobe |
| fill_vpn | input | 20 | Virtual page tag of the descriptor (4 KB granularity) |
| fill_frame | input | 20 | Physical frame number (4 KB granularity) |
| fill_wp | input | 1 | Write-protect flag |
| fill_sup | input | 1 | Supervisor-only flag |
| fill_cmode | input | 2 | Cache-mode code |
| fill_vtype | input | 2 | Valid type; 00 = invalid descriptor |

## Verification
The bench aims at the cases where a translation cache most easily goes wrong: an invalid descriptor that gets installed anyway (a second access would then hit silently instead of faulting), a rights check applied to the wrong request flag (a read of a write-protected page would fault, or a user write would pass), and an 8 KB mode that still compares address bit 12 (the second half of a page would miss and walk). It also drives 65 distinct fills after a flush and then touches the oldest pages, which exposes a pointer that does not wrap or that skips entries, and checks that a flush really forces new walks rather than leaving stale mappings. Random traffic over a page pool larger than the buffer, in 4 KB, 8 KB and pass-through modes, then mixes hits, misses and evictions against a descriptor function computed in the bench.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    CM_WRTHRU = 2'b00,
    CM_COPYBK = 2'b01,
    CM_SERIAL = 2'b10,
    CM_NOCACH = 2'b11
  } cmode_e;

  typedef struct packed {
    logic   wp;
    logic   sup;
    cmode_e cmode;
  } perm_t;

  localparam logic [1:0] VT_INVALID = 2'b00;

endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int ENTRIES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             pg8k,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             hit,
  output logic [VPN_W-1:0] hit_frame,
  output perm_t            hit_perm,
  input  logic             we,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [VPN_W-1:0] wr_frame,
  input  perm_t            wr_perm
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   tag_q   [ENTRIES];
  logic [VPN_W-1:0]   frame_q [ENTRIES];
  perm_t              perm_q  [ENTRIES];
  logic [IDX_W-1:0]   ptr;
  logic [ENTRIES-1:0] match;
  logic [VPN_W-1:0]   cmp_mask;

  // 8 KB pages ignore the lowest tag bit
  assign cmp_mask = pg8k ? {{(VPN_W-1){1'b1}}, 1'b0} : {VPN_W{1'b1}};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = vld[i] && (((tag_q[i] ^ look_vpn) & cmp_mask) == '0);
  end

  always_comb begin
    hit       = 1'b0;
    hit_frame = '0;
    hit_perm  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hit       = 1'b1;
        hit_frame = hit_frame | frame_q[i];
        hit_perm  = hit_perm | perm_q[i];
      end
    end
  end

  // Payload storage: written only, no reset, no flush
  always_ff @(posedge clk) begin
    if (we) begin
      tag_q[ptr]   <= wr_vpn;
      frame_q[ptr] <= wr_frame;
      perm_q[ptr]  <= wr_perm;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      ptr <= '0;
    end else begin
      if (flush)   vld      <= '0;
      else if (we) vld[ptr] <= 1'b1;
      if (we) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  // R6: flush leaves no valid entry
  a_r6_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld == '0));

  // R10: every fill moves the replacement pointer on
  a_r10_ptr_moves: assert property (@(posedge clk) disable iff (rst)
    we |=> (ptr != $past(ptr)));

  // R1: fills only follow misses, so at most one entry matches
  a_r1_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));

endmodule

// File: rtl/tlb_access_check.sv
module tlb_access_check
  import tlb_pkg::*;
(
  input  perm_t perm,
  input  logic  is_write,
  input  logic  is_super,
  output logic  fault
);

  logic wr_block, usr_block;

  assign wr_block  = is_write && perm.wp;
  assign usr_block = !is_super && perm.sup;
  assign fault     = wr_block || usr_block;

endmodule

// File: rtl/mmu_xlate_cache.sv
module mmu_xlate_cache
  import tlb_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRIES    = 64,
  localparam int VPN_W     = VA_W - PAGE_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xlate_en,
  input  logic             page_8k,
  input  logic             flush_all,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_write,
  input  logic             req_super,
  output logic             rsp_valid,
  output logic [VA_W-1:0]  rsp_pa,
  output logic [1:0]       rsp_cmode,
  output logic             rsp_fault,
  output logic             walk_req,
  output logic [VA_W-1:0]  walk_va,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [VPN_W-1:0] fill_frame,
  input  logic             fill_wp,
  input  logic             fill_sup,
  input  logic [1:0]       fill_cmode,
  input  logic [1:0]       fill_vtype
);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RETRY} state_e;

  state_e          state;
  logic [VA_W-1:0] held_va;
  logic            held_wr, held_su;

  logic [VA_W-1:0]  lk_va;
  logic             lk_wr, lk_su;
  logic             hit, perm_fault;
  logic [VPN_W-1:0] hit_frame;
  perm_t            hit_perm, fill_perm;
  logic [VA_W-1:0]  xpa;
  logic             accept, fill_take, fill_bad, fill_we;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign walk_va   = held_va;

  assign lk_va = (state == ST_RETRY) ? held_va : req_va;
  assign lk_wr = (state == ST_RETRY) ? held_wr : req_write;
  assign lk_su = (state == ST_RETRY) ? held_su : req_super;

  assign fill_take = (state == ST_WAIT) && fill_valid;
  assign fill_bad  = fill_take && (fill_vtype == VT_INVALID);
  assign fill_we   = fill_take && (fill_vtype != VT_INVALID);
  assign fill_perm = '{wp: fill_wp, sup: fill_sup, cmode: cmode_e'(fill_cmode)};

  assign xpa = page_8k ? {hit_frame[VPN_W-1:1], lk_va[PAGE_SHIFT:0]}
                       : {hit_frame, lk_va[PAGE_SHIFT-1:0]};

  tlb_entry_array #(.VPN_W(VPN_W), .ENTRIES(ENTRIES)) u_arr (
    .clk(clk), .rst(rst), .flush(flush_all), .pg8k(page_8k),
    .look_vpn(lk_va[VA_W-1:PAGE_SHIFT]),
    .hit(hit), .hit_frame(hit_frame), .hit_perm(hit_perm),
    .we(fill_we), .wr_vpn(fill_vpn), .wr_frame(fill_frame), .wr_perm(fill_perm)
  );

  tlb_access_check u_chk (
    .perm(hit_perm), .is_write(lk_wr), .is_super(lk_su), .fault(perm_fault)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      held_va   <= '0;
      held_wr   <= 1'b0;
      held_su   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_cmode <= 2'b00;
      rsp_fault <= 1'b0;
      walk_req  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          held_va <= req_va;
          held_wr <= req_write;
          held_su <= req_super;
          if (!xlate_en) begin
            rsp_valid <= 1'b1;
            rsp_pa    <= req_va;
            rsp_cmode <= 2'b00;
            rsp_fault <= 1'b0;
          end else if (hit) begin
            rsp_valid <= 1'b1;
            rsp_fault <= perm_fault;
            rsp_pa    <= perm_fault ? '0 : xpa;
            rsp_cmode <= perm_fault ? 2'b00 : hit_perm.cmode;
          end else begin
            state    <= ST_WAIT;
            walk_req <= 1'b1;
          end
        end
        ST_WAIT: if (fill_valid) begin
          walk_req <= 1'b0;
          if (fill_vtype == VT_INVALID) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_pa    <= '0;
            rsp_cmode <= 2'b00;
            state     <= ST_IDLE;
          end else begin
            state <= ST_RETRY;
          end
        end
        ST_RETRY: begin
          if (!xlate_en) begin
            rsp_valid <= 1'b1;
            rsp_pa    <= held_va;
            rsp_cmode <= 2'b00;
            rsp_fault <= 1'b0;
            state     <= ST_IDLE;
          end else if (hit) begin
            rsp_valid <= 1'b1;
            rsp_fault <= perm_fault;
            rsp_pa    <= perm_fault ? '0 : xpa;
            rsp_cmode <= perm_fault ? 2'b00 : hit_perm.cmode;
            state     <= ST_IDLE;
          end else begin
            walk_req <= 1'b1;
            state    <= ST_WAIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: pass-through when translation is off
  a_r8_bypass: assert property (@(posedge clk) disable iff (rst)
    accept && !xlate_en |=> rsp_valid && !rsp_fault && (rsp_pa == $past(req_va)));

  // R2: protected page refuses a write
  a_r2_wp_write: assert property (@(posedge clk) disable iff (rst)
    accept && xlate_en && hit && req_write && hit_perm.wp |=> rsp_valid && rsp_fault);

  // R3: supervisor-only page refuses a user access
  a_r3_user_sup: assert property (@(posedge clk) disable iff (rst)
    accept && xlate_en && hit && !req_super && hit_perm.sup |=> rsp_valid && rsp_fault);

  // R4: invalid descriptor ends the request with a fault
  a_r4_invalid_fill: assert property (@(posedge clk) disable iff (rst)
    fill_bad |=> rsp_valid && rsp_fault);

  // R9: walk request and its address stay put until answered
  a_r9_walk_hold: assert property (@(posedge clk) disable iff (rst)
    walk_req && !fill_valid |=> walk_req && $stable(walk_va) && !req_ready);

  // R11: fault responses carry no address or cache mode
  a_r11_fault_clean: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> (rsp_pa == '0) && (rsp_cmode == 2'b00));

endmodule

// File: tb/sim_mmu_xlate_cache.sv
`timescale 1ns/1ps
module sim_mmu_xlate_cache;

  logic        clk = 1'b0;
  logic        rst, xlate_en, page_8k, flush_all;
  logic        req_valid, req_ready, req_write, req_super;
  logic [31:0] req_va;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_cmode;
  logic        walk_req;
  logic [31:0] walk_va;
  logic        fill_valid, fill_wp, fill_sup;
  logic [19:0] fill_vpn, fill_frame;
  logic [1:0]  fill_cmode, fill_vtype;

  always #2.5 clk = ~clk;

  mmu_xlate_cache u0 (
    .clk(clk), .rst(rst), .xlate_en(xlate_en), .page_8k(page_8k), .flush_all(flush_all),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .req_super(req_super),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_cmode(rsp_cmode), .rsp_fault(rsp_fault),
    .walk_req(walk_req), .walk_va(walk_va),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_frame(fill_frame),
    .fill_wp(fill_wp), .fill_sup(fill_sup), .fill_cmode(fill_cmode), .fill_vtype(fill_vtype)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  // Page-table contents as a function of the 4 KB page number
  function automatic logic [19:0] d_frame(logic [19:0] v); return {v[9:0], v[19:10]} ^ 20'h5A5A4; endfunction
  function automatic logic d_wp(logic [19:0] v); return v[3]; endfunction
  function automatic logic d_sup(logic [19:0] v); return v[4]; endfunction
  function automatic logic [1:0] d_cm(logic [19:0] v); return v[6:5]; endfunction
  function automatic logic [1:0] d_vt(logic [19:0] v);
    return (v[9:7] == 3'b000) ? 2'b00 : (v[1] ? 2'b10 : 2'b01);
  endfunction
  function automatic logic [19:0] key(logic [31:0] va);
    return page_8k ? {va[31:13], 1'b0} : va[31:12];
  endfunction
  function automatic logic [19:0] mk(logic [9:0] hi, logic wp, logic sup, logic [1:0] cm, logic ok);
    return {hi, ok ? 3'b001 : 3'b000, cm, sup, wp, 3'b000};
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  logic        a_walked;
  int          a_fills, a_lat;
  logic [31:0] a_pa;
  logic [1:0]  a_cm;
  logic        a_flt;

  task automatic access(input logic [31:0] va, input logic w, input logic s);
    a_walked = 0; a_fills = 0; a_lat = -1;
    @(negedge clk);
    req_valid = 1; req_va = va; req_write = w; req_super = s;
    @(negedge clk);
    req_valid = 0;
    for (int t = 0; t < 40; t++) begin
      if (rsp_valid) begin a_lat = t; break; end
      if (walk_req) begin
        if (!a_walked) begin
          check("R9 walk_va", {32'd0, walk_va}, {32'd0, va});
          check("R9 ready low", {63'd0, req_ready}, 64'd0);
        end
        a_walked = 1; a_fills++;
        fill_valid = 1; fill_vpn = walk_va[31:12];
        fill_frame = d_frame(key(walk_va)); fill_wp = d_wp(key(walk_va));
        fill_sup = d_sup(key(walk_va)); fill_cmode = d_cm(key(walk_va));
        fill_vtype = d_vt(key(walk_va));
        @(negedge clk);
        fill_valid = 0;
      end else @(negedge clk);
    end
    a_pa = rsp_pa; a_cm = rsp_cmode; a_flt = rsp_fault;
  endtask

  // Compares the last response with the value computed from the page table
  task automatic expect_rsp(string req, logic [31:0] va, logic w, logic s);
    logic [31:0] epa; logic [1:0] ecm; logic ef;
    logic [19:0] k;
    k = key(va);
    if (!xlate_en) begin epa = va; ecm = 2'b00; ef = 0; end
    else if (d_vt(k) == 2'b00 || (w && d_wp(k)) || (!s && d_sup(k))) begin
      epa = 0; ecm = 2'b00; ef = 1;
    end else begin
      ecm = d_cm(k); ef = 0;
      epa = page_8k ? {d_frame(k)[19:1], va[12:0]} : {d_frame(k), va[11:0]};
    end
    check(req, {29'd0, a_flt, a_cm, a_pa}, {29'd0, ef, ecm, epa});
    if (a_lat < 0) check({req, " no response"}, 64'd0, 64'd1);
  endtask

  task automatic do_flush();
    @(negedge clk); flush_all = 1;
    @(negedge clk); flush_all = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  logic [31:0] va;
  logic [19:0] v;

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; xlate_en = 0; page_8k = 0; flush_all = 0;
    req_valid = 0; req_va = 0; req_write = 0; req_super = 0;
    fill_valid = 0; fill_vpn = 0; fill_frame = 0; fill_wp = 0; fill_sup = 0;
    fill_cmode = 0; fill_vtype = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12: reset state
    check("R12 reset", {61'd0, req_ready, rsp_valid, walk_req}, {61'd0, 3'b100});

    xlate_en = 1;
    // R1/R9: first access walks, second hits in one cycle
    v = mk(10'h011, 0, 0, 2'b01, 1); va = {v, 12'h3A4};
    access(va, 0, 0);
    check("R9 miss walks", {63'd0, a_walked}, 64'd1);
    expect_rsp("R9 retry response", va, 0, 0);
    access(va, 0, 0);
    check("R1 hit no walk", {63'd0, a_walked}, 64'd0);
    check("R1 hit latency", a_lat, 0);
    expect_rsp("R1 hit translation", va, 0, 0);

    // R2: write protection
    v = mk(10'h022, 1, 0, 2'b00, 1); va = {v, 12'h010};
    access(va, 0, 0); expect_rsp("R2 read of protected page", va, 0, 0);
    access(va, 1, 1); expect_rsp("R2 write faults", va, 1, 1);
    check("R2 fault flag", {63'd0, a_flt}, 64'd1);

    // R3: supervisor-only page
    v = mk(10'h033, 0, 1, 2'b10, 1); va = {v, 12'hFFC};
    access(va, 0, 1); expect_rsp("R3 supervisor allowed", va, 0, 1);
    access(va, 0, 0); expect_rsp("R3 user faults", va, 0, 0);
    check("R3 fault flag", {63'd0, a_flt}, 64'd1);

    // R4/R11: invalid descriptor faults and is not kept
    v = mk(10'h044, 0, 0, 2'b11, 0); va = {v, 12'h000};
    access(va, 0, 1); expect_rsp("R4 invalid faults", va, 0, 1);
    check("R11 fault pa", {32'd0, a_pa}, 64'd0);
    access(va, 0, 1);
    check("R4 not installed", {63'd0, a_walked}, 64'd1);

    // R7: each cache-mode code
    for (int c = 0; c < 4; c++) begin
      v = mk(10'h050 + 10'(c), 0, 0, 2'(c), 1); va = {v, 12'h123};
      access(va, 1, 0);
      check("R7 cache mode", {62'd0, a_cm}, 64'(c));
    end

    // R6: flush forces a new walk
    v = mk(10'h011, 0, 0, 2'b01, 1); va = {v, 12'h000};
    access(va, 0, 0);
    check("R6 before flush hit", {63'd0, a_walked}, 64'd0);
    do_flush();
    access(va, 0, 0);
    check("R6 after flush walks", {63'd0, a_walked}, 64'd1);

    // R10: round robin over 64 entries
    do_flush();
    for (int i = 0; i < 65; i++) begin
      va = {10'(i), 10'h080, 12'h000};
      access(va, 0, 1);
    end
    va = {10'd1, 10'h080, 12'h000}; access(va, 0, 1);
    check("R10 second page kept", {63'd0, a_walked}, 64'd0);
    va = {10'd64, 10'h080, 12'h000}; access(va, 0, 1);
    check("R10 newest page kept", {63'd0, a_walked}, 64'd0);
    va = {10'd0, 10'h080, 12'h000}; access(va, 0, 1);
    check("R10 oldest page evicted", {63'd0, a_walked}, 64'd1);

    // R5: 8 KB pages
    do_flush(); page_8k = 1;
    v = mk(10'h066, 0, 0, 2'b01, 1); va = {v[19:1], 1'b0, 12'h456};
    access(va, 0, 0); expect_rsp("R5 8k low half", va, 0, 0);
    va = {v[19:1], 1'b1, 12'h456};
    access(va, 0, 0);
    check("R5 8k high half hits", {63'd0, a_walked}, 64'd0);
    expect_rsp("R5 8k high half pa", va, 0, 0);

    // R8: translation disabled
    xlate_en = 0;
    va = {mk(10'h044, 1, 1, 2'b11, 0), 12'hABC};
    access(va, 1, 0);
    check("R8 no walk", {63'd0, a_walked}, 64'd0);
    expect_rsp("R8 pass-through", va, 1, 0);

    // Random traffic in three modes
    for (int ph = 0; ph < 3; ph++) begin
      do_flush();
      @(negedge clk);
      page_8k = (ph == 1); xlate_en = (ph != 2);
      for (int n = 0; n < 700; n++) begin
        logic w, s;
        v = 20'(($urandom % 150) * 20'd3761);
        va = {v, 12'($urandom)};
        w = 1'($urandom); s = 1'($urandom);
        access(va, w, s);
        expect_rsp(ph == 2 ? "R8 random" : (ph == 1 ? "R5 random 8k" : "R1 random 4k"), va, w, s);
        if (!a_walked) check("R1 random hit latency", a_lat, 0);
      end
    end

    finish_run();
  end

endmodule